// File: doc/BRIEF.md
# Table-Driven Case Dispatch Unit

This block implements a switch-case in hardware as two operations. The prepare operation reads a case count and a 16-bit resume address that follow its opcode in program memory. It pushes the resume address onto a downward-growing stack held in the scratchpad and keeps the count in an internal register. The scan operation then walks an inline table that follows its own opcode. Each table entry is a match byte followed by a 16-bit target. The accumulator, latched when the scan is accepted, is compared against each entry in turn. The first equal entry supplies the new program counter. If no entry matches, a trailing default target is used instead. The called routine later returns to the pushed resume address.

The sequencer around this block presents one operation at a time with its opcode address and the accumulator. The block fetches its own operand bytes through an asynchronous program-memory read port, where data is valid in the same cycle as the address. It writes stack bytes through a scratchpad write port. When it finishes, it hands back the next program counter with a one-cycle done pulse. Phase lengths are parameters. With the defaults, a scan that takes the default target lasts 5+7·d cycles.

Top module: `case_disp_unit`

## Requirements
- R1: After reset, busy_o and done_o are 0, sp_o is 0x5B, zero_o is 0 and count_o is 0.
- R2: For opcode 0x7A at address P, the block reads the count from P+1, the resume low byte from P+2 and the high byte from P+3. It stays busy for 9 cycles. It then pulses done_o for one cycle with pc_o = P+4 and count_o equal to the count read.
- R3: The prepare operation writes the resume high byte to scratchpad address R−1 and the low byte to R−2, where R is sp_o before the operation. It then leaves sp_o at R−2 (7-bit wrap).
- R4: For opcode 0x69 at address P, entry i (counting from 0) sits at P+1+3i as a match byte, then the target low byte, then the target high byte. The first entry whose match byte equals the accumulator sampled at acceptance gives pc_o, even if later entries also match.
- R5: A match at entry i (counting from 1) sets zero_o to 1 and keeps the block busy for 7·i cycles.
- R6: When none of the d entries matches, the target is read low byte first from P+1+3d. zero_o is cleared and the block is busy for 7·d+5 cycles.
- R7: With a count of 0, the scan compares nothing. It reads the default target at P+1 and is busy for 5 cycles.
- R8: An op_valid_i carrying any opcode other than 0x7A or 0x69 is ignored. There is no busy cycle, no done pulse and no stack write.
- R9: An op_valid_i that arrives while busy_o is 1 is ignored. The running operation's result and timing are unchanged.
- R10: A scan leaves count_o unchanged, so repeating the same scan with the same accumulator gives the same target.
- R11: zero_o changes only in a cycle where done_o is 1, and a prepare leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request |
| opcode_i | input | 8 | Opcode of the requested operation |
| op_pc_i | input | 16 | Address of the opcode byte |
| acc_i | input | 8 | Accumulator, latched on acceptance |
| pmem_rd_o | output | 1 | Program-memory read strobe |
| pmem_addr_o | output | 16 | Program-memory read address |
| pmem_data_i | input | 8 | Program-memory read data, same cycle |
| sp_we_o | output | 1 | Scratchpad write enable |
| sp_addr_o | output | 7 | Scratchpad write address |
| sp_wdata_o | output | 8 | Scratchpad write data |
| sp_o | output | 7 | Current stack pointer R |
| count_o | output | 8 | Stored case count d |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Next program counter, valid with done_o |
| zero_o | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters: an 8-bit count and phase lengths of 9, 7 and 5 cycles. These defaults make the full 5+7·d scan timing observable. The 8-bit count allows a 255-entry table, so the bench can exercise both a miss on every entry (1790 busy cycles) and a hit on the very last entry. Zero-count and nested prepares move the stack pointer through three frames. Requests injected mid-operation, together with an accumulator changed during a scan, show that the latched inputs decide the result.

// File: rtl/case_disp_pkg.sv
package case_disp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_ENTRY,
    ST_DEFAULT
  } disp_state_e;

  localparam logic [7:0] OPC_PREP = 8'h7A;
  localparam logic [7:0] OPC_SCAN = 8'h69;
endpackage

// File: rtl/case_disp_timer.sv
module case_disp_timer #(
  parameter int TICK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TICK_W-1:0] len_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              last_o
);
  logic [TICK_W-1:0] tick_q;

  assign last_o = run_i && (tick_q == len_i - 1'b1);
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else if (!run_i || last_o) tick_q <= '0;
    else tick_q <= tick_q + 1'b1;
  end

  p_tick_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (tick_q < len_i));
endmodule

// File: rtl/case_disp_stack.sv
module case_disp_stack #(
  parameter int              SP_W = 7,
  parameter logic [SP_W-1:0] TOP  = 7'h5B
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  input  logic [7:0]      data_i,
  input  logic            commit_i,
  output logic            we_o,
  output logic [SP_W-1:0] addr_o,
  output logic [7:0]      wdata_o,
  output logic [SP_W-1:0] sp_o
);
  logic [SP_W-1:0] sp_q;

  assign we_o    = wr_hi_i | wr_lo_i;
  assign addr_o  = sp_q - (wr_hi_i ? SP_W'(1) : SP_W'(2));
  assign wdata_o = data_i;
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= TOP;
    else if (commit_i) sp_q <= sp_q - SP_W'(2);
  end

  p_sp_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) - SP_W'(2)));
endmodule

// File: rtl/case_disp_seq.sv
module case_disp_seq
  import case_disp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter int TICK_W   = 4,
  parameter int PREP_CYC = 9,
  parameter int ENT_CYC  = 7,
  parameter int DEF_CYC  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] op_pc_i,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        pmem_data_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              last_i,
  output logic              run_o,
  output logic [TICK_W-1:0] len_o,
  output logic              pmem_rd_o,
  output logic [ADDR_W-1:0] pmem_addr_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic [7:0]        stk_data_o,
  output logic              commit_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              zero_o
);
  disp_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q, pc_q;
  logic [CNT_W-1:0]  count_q, remain_q, cnt_tmp_q;
  logic [7:0]        acc_q, lo_q, hi_q;
  logic              hit_q, done_q, zero_q;
  logic              accept;

  assign accept = op_valid_i && (state_q == ST_IDLE) &&
                  ((opcode_i == OPC_PREP) || (opcode_i == OPC_SCAN));

  always_comb begin
    run_o     = (state_q != ST_IDLE);
    len_o     = TICK_W'(1);
    pmem_rd_o = 1'b0;
    unique case (state_q)
      ST_PREP: begin
        len_o     = TICK_W'(PREP_CYC);
        pmem_rd_o = (tick_i < TICK_W'(3));
      end
      ST_ENTRY: begin
        len_o     = TICK_W'(ENT_CYC);
        pmem_rd_o = (tick_i < TICK_W'(3));
      end
      ST_DEFAULT: begin
        len_o     = TICK_W'(DEF_CYC);
        pmem_rd_o = (tick_i < TICK_W'(2));
      end
      default: ;
    endcase
  end

  assign pmem_addr_o = ptr_q + ADDR_W'(tick_i);
  assign wr_hi_o     = (state_q == ST_PREP) && (tick_i == TICK_W'(3));
  assign wr_lo_o     = (state_q == ST_PREP) && (tick_i == TICK_W'(4));
  assign stk_data_o  = wr_hi_o ? hi_q : lo_q;
  assign commit_o    = (state_q == ST_PREP) && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      pc_q      <= '0;
      count_q   <= '0;
      remain_q  <= '0;
      cnt_tmp_q <= '0;
      acc_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      hit_q     <= 1'b0;
      done_q    <= 1'b0;
      zero_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ptr_q    <= op_pc_i + ADDR_W'(1);
            acc_q    <= acc_i;
            remain_q <= count_q;
            if (opcode_i == OPC_PREP) state_q <= ST_PREP;
            else if (count_q == '0)   state_q <= ST_DEFAULT;
            else                      state_q <= ST_ENTRY;
          end
        end
        ST_PREP: begin
          if (tick_i == TICK_W'(0)) cnt_tmp_q <= pmem_data_i;
          if (tick_i == TICK_W'(1)) lo_q      <= pmem_data_i;
          if (tick_i == TICK_W'(2)) hi_q      <= pmem_data_i;
          if (last_i) begin
            count_q <= cnt_tmp_q;
            pc_q    <= ptr_q + ADDR_W'(3);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_ENTRY: begin
          if (tick_i == TICK_W'(0)) hit_q <= (pmem_data_i == acc_q);
          if (tick_i == TICK_W'(1)) lo_q  <= pmem_data_i;
          if (tick_i == TICK_W'(2)) hi_q  <= pmem_data_i;
          if (last_i) begin
            if (hit_q) begin
              pc_q    <= {hi_q, lo_q};
              zero_q  <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              ptr_q    <= ptr_q + ADDR_W'(3);
              remain_q <= remain_q - 1'b1;
              if (remain_q == CNT_W'(1)) state_q <= ST_DEFAULT;
            end
          end
        end
        ST_DEFAULT: begin
          if (tick_i == TICK_W'(0)) lo_q <= pmem_data_i;
          if (tick_i == TICK_W'(1)) hi_q <= pmem_data_i;
          if (last_i) begin
            pc_q    <= {hi_q, lo_q};
            zero_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign count_o = count_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign pc_o    = pc_q;
  assign zero_o  = zero_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(state_q) != ST_IDLE) && (state_q == ST_IDLE));
  p_zero_at_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(zero_q) |-> done_q);
  p_count_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_q) |-> (done_q && $past(state_q) == ST_PREP));
endmodule

// File: rtl/case_disp_unit.sv
module case_disp_unit #(
  parameter int          ADDR_W    = 16,
  parameter int          CNT_W     = 8,
  parameter int          SP_W      = 7,
  parameter logic [6:0]  STACK_TOP = 7'h5B,
  parameter int          PREP_CYC  = 9,
  parameter int          ENT_CYC   = 7,
  parameter int          DEF_CYC   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] op_pc_i,
  input  logic [7:0]        acc_i,
  output logic              pmem_rd_o,
  output logic [ADDR_W-1:0] pmem_addr_o,
  input  logic [7:0]        pmem_data_i,
  output logic              sp_we_o,
  output logic [SP_W-1:0]   sp_addr_o,
  output logic [7:0]        sp_wdata_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              zero_o
);
  localparam int TICK_W = $clog2(PREP_CYC + ENT_CYC + DEF_CYC + 1);

  logic              run, last, wr_hi, wr_lo, commit;
  logic [TICK_W-1:0] len, tick;
  logic [7:0]        stk_data;

  case_disp_timer #(.TICK_W(TICK_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .len_i (len),
    .tick_o(tick),
    .last_o(last)
  );

  case_disp_stack #(.SP_W(SP_W), .TOP(SP_W'(STACK_TOP))) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hi_i (wr_hi),
    .wr_lo_i (wr_lo),
    .data_i  (stk_data),
    .commit_i(commit),
    .we_o    (sp_we_o),
    .addr_o  (sp_addr_o),
    .wdata_o (sp_wdata_o),
    .sp_o    (sp_o)
  );

  case_disp_seq #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .TICK_W  (TICK_W),
    .PREP_CYC(PREP_CYC),
    .ENT_CYC (ENT_CYC),
    .DEF_CYC (DEF_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .opcode_i   (opcode_i),
    .op_pc_i    (op_pc_i),
    .acc_i      (acc_i),
    .pmem_data_i(pmem_data_i),
    .tick_i     (tick),
    .last_i     (last),
    .run_o      (run),
    .len_o      (len),
    .pmem_rd_o  (pmem_rd_o),
    .pmem_addr_o(pmem_addr_o),
    .wr_hi_o    (wr_hi),
    .wr_lo_o    (wr_lo),
    .stk_data_o (stk_data),
    .commit_o   (commit),
    .count_o    (count_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pc_o       (pc_o),
    .zero_o     (zero_o)
  );
endmodule

// File: tb/test_case_disp_unit.sv
`timescale 1ns/1ps
module test_case_disp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] op_pc = 16'h0;
  logic [7:0]  acc = 8'h00;
  logic        pmem_rd, sp_we, busy, done, zero;
  logic [15:0] pmem_addr, pc;
  logic [7:0]  pmem_data, sp_wdata, count;
  logic [6:0]  sp_addr, sp;

  logic [7:0] pmem [0:2047];
  logic [7:0] scr [0:127];
  logic [7:0] exp_scr [0:127];
  int n_chk = 0, n_err = 0;
  int m_sp = 'h5B, m_cnt = 0;
  logic m_zero = 1'b0;

  always #2.5 clk = ~clk;
  assign pmem_data = pmem[pmem_addr[10:0]];

  case_disp_unit i_case_disp_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .opcode_i(opcode),
    .op_pc_i(op_pc), .acc_i(acc), .pmem_rd_o(pmem_rd), .pmem_addr_o(pmem_addr),
    .pmem_data_i(pmem_data), .sp_we_o(sp_we), .sp_addr_o(sp_addr),
    .sp_wdata_o(sp_wdata), .sp_o(sp), .count_o(count), .busy_o(busy),
    .done_o(done), .pc_o(pc), .zero_o(zero)
  );

  always @(posedge clk) if (sp_we) scr[sp_addr] <= sp_wdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_tgt(int a, logic [15:0] t);
    pmem[a]   = t[7:0];
    pmem[a+1] = t[15:8];
  endtask

  function automatic logic [15:0] rd16(int a);
    return {pmem[(a+1) & 2047], pmem[a & 2047]};
  endfunction

  // Behavioural reference plus per-cycle busy/done comparison
  task automatic run_op(string req, logic [7:0] opc, logic [15:0] p, logic [7:0] a, bit poke);
    int len = 0, bad = 0;
    logic [15:0] epc = '0;
    bit prep = (opc == 8'h7A);
    if (prep) begin
      epc = p + 16'd4;
      len = 9;
      exp_scr[(m_sp-1) & 127] = pmem[p+3];
      exp_scr[(m_sp-2) & 127] = pmem[p+2];
      m_sp  = (m_sp - 2) & 127;
      m_cnt = pmem[p+1];
    end else begin
      bit hit = 0;
      for (int i = 0; i < m_cnt; i++) begin
        if (!hit && pmem[p+1+3*i] == a) begin
          hit = 1; epc = rd16(p+2+3*i); len = 7*(i+1);
        end
      end
      if (!hit) begin
        epc = rd16(p+1+3*m_cnt); len = 7*m_cnt + 5;
      end
      m_zero = hit;
    end
    @(negedge clk);
    op_valid = 1'b1; opcode = opc; op_pc = p; acc = a;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      acc = ~a;
      if (poke && k == 1) begin
        op_valid = 1'b1; opcode = 8'h7A; op_pc = 16'h0010;
      end
      if (busy !== 1'b1 || done !== 1'b0) bad++;
    end
    chk({req, " busy window"}, bad, 0);
    @(negedge clk);
    chk({req, " done"}, {busy, done}, 2'b01);
    chk({req, " pc"}, pc, epc);
    chk({req, " zero R11"}, zero, m_zero);
    chk({req, " sp R3"}, sp, m_sp);
    chk({req, " count R10"}, count, m_cnt);
    if (prep) begin
      chk({req, " stack hi R3"}, scr[(m_sp+1) & 127], exp_scr[(m_sp+1) & 127]);
      chk({req, " stack lo R3"}, scr[m_sp], exp_scr[m_sp]);
    end
    @(negedge clk);
    chk({req, " done pulse R2"}, {busy, done}, 2'b00);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < 2048; i++) pmem[i] = 8'h00;
    for (int i = 0; i < 128; i++) begin scr[i] = 8'h00; exp_scr[i] = 8'h00; end
    pmem['h010] = 8'h7A; pmem['h011] = 8'h03; put_tgt('h012, 16'h1234);
    pmem['h020] = 8'h69;
    pmem['h021] = 8'h11; put_tgt('h022, 16'hA000);
    pmem['h024] = 8'h22; put_tgt('h025, 16'hB000);
    pmem['h027] = 8'h11; put_tgt('h028, 16'hC000);
    put_tgt('h02A, 16'hD000);
    pmem['h040] = 8'h7A; pmem['h041] = 8'h00; put_tgt('h042, 16'h5678);
    pmem['h060] = 8'h69; pmem['h061] = 8'hEF; pmem['h062] = 8'hBE;
    pmem['h080] = 8'h7A; pmem['h081] = 8'hFF; put_tgt('h082, 16'h4000);
    pmem['h100] = 8'h69;
    for (int i = 0; i < 255; i++) begin
      pmem['h101 + 3*i] = 8'(i);
      put_tgt('h102 + 3*i, 16'h9000 + 16'(i));
    end
    put_tgt('h101 + 3*255, 16'hCAFE);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy/done", {busy, done}, 2'b00);
    chk("R1 sp", sp, 7'h5B);
    chk("R1 zero", zero, 1'b0);
    chk("R1 count", count, 8'h00);

    run_op("R2 R3 prepare", 8'h7A, 16'h0010, 8'h00, 0);
    run_op("R4 R5 hit second", 8'h69, 16'h0020, 8'h22, 0);
    run_op("R4 first of two", 8'h69, 16'h0020, 8'h11, 0);
    run_op("R6 default", 8'h69, 16'h0020, 8'h33, 0);
    run_op("R10 repeat", 8'h69, 16'h0020, 8'h22, 0);

    // R8: unsupported opcode
    @(negedge clk);
    op_valid = 1'b1; opcode = 8'h5A; op_pc = 16'h0010;
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      if (busy !== 1'b0 || done !== 1'b0 || sp_we !== 1'b0) bad++;
    end
    chk("R8 unknown ignored", bad, 0);
    chk("R8 sp unchanged", sp, m_sp);

    run_op("R3 nested zero count", 8'h7A, 16'h0040, 8'h00, 0);
    run_op("R7 zero count", 8'h69, 16'h0060, 8'hEF, 0);
    run_op("R9 prepare with poke", 8'h7A, 16'h0080, 8'h00, 1);
    run_op("R6 255 misses", 8'h69, 16'h0100, 8'hFF, 0);
    run_op("R9 R5 last entry with poke", 8'h69, 16'h0100, 8'hFE, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule